// File: doc/BRIEF.md
# PWM Event to ADC Trigger Selector

This block sits between one even/odd pair of PWM channels and an ADC. Each cycle it receives the single-cycle event strobes that the pair's counters produce: counter at zero, counter at period, and the compare hits while counting up or down for the even channel, plus the up-count and down-count compare hits for the odd channel. A 4-bit condition code selects which of these events starts a conversion. When the selected event fires and triggering is enabled, the block emits a start-of-conversion pulse in that same cycle.

The block also keeps a sticky status flag that records that at least one trigger was issued. Software reads the flag and clears it with a strobe. If a trigger and a clear land in the same cycle, the flag stays set, so no trigger goes unrecorded. The reset input is asserted asynchronously and released through an internal synchronizer. Until that release has gone through, no trigger is issued.

Top module: `pwm_adc_trig_sel`

## Requirements
- R1: Condition code 0 issues a trigger when the even channel's zero event is present.
- R2: Condition code 1 issues a trigger when the even channel's period event is present.
- R3: Condition code 2 issues a trigger when either the even channel's zero event or its period event is present.
- R4: Condition code 3 issues a trigger on the even channel's up-count compare event, and code 4 issues one on its down-count compare event.
- R5: Condition code 8 issues a trigger on the odd channel's up-count compare event, and code 9 issues one on its down-count compare event.
- R6: Condition codes 5, 6, 7 and 10 to 15 never issue a trigger, whatever the events.
- R7: While the trigger enable is low, no trigger is issued and the flag is not set.
- R8: The trigger is combinational. It is high only in a cycle where the selected event is present, so an event lasting one cycle gives a pulse lasting one cycle.
- R9: A trigger sets the flag from the next clock edge on, and the flag stays set until it is cleared.
- R10: A clear strobe with no trigger in the same cycle drops the flag at the next edge. A clear in the same cycle as a trigger leaves the flag set.
- R11: While reset is asserted, and for two clock edges after it is released, the trigger is low and the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evn_zero_i | input | 1 | Even channel counter-at-zero event |
| evn_prd_i | input | 1 | Even channel counter-at-period event |
| evn_cmp_up_i | input | 1 | Even channel compare hit while counting up |
| evn_cmp_dn_i | input | 1 | Even channel compare hit while counting down |
| odd_cmp_up_i | input | 1 | Odd channel compare hit while counting up |
| odd_cmp_dn_i | input | 1 | Odd channel compare hit while counting down |
| cond_i | input | 4 | Condition code that selects the trigger source |
| trig_en_i | input | 1 | Trigger enable |
| flag_clr_i | input | 1 | Flag clear strobe |
| trig_o | output | 1 | ADC start-of-conversion pulse |
| flag_o | output | 1 | Sticky trigger flag |

## Verification
The hardest case to reach is a clear strobe that coincides with a qualifying event. It has to arrive both while the flag is already set and while it is still clear, because only then does the set-wins rule show up at the flag. The stimulus first aims such collisions on purpose. It then runs a long pseudo-random stretch in which events, codes, enable and clear change every cycle, so collisions under every code, including the unlisted ones, occur many times over.

// File: rtl/adctrg_pkg.sv
package adctrg_pkg;

  localparam int unsigned COND_W = 4;

  // Condition codes; the sparse values are part of the block's behaviour.
  typedef enum logic [COND_W-1:0] {
    SEL_EVN_ZERO  = 4'd0,
    SEL_EVN_PRD   = 4'd1,
    SEL_EVN_ZP    = 4'd2,
    SEL_EVN_CUP   = 4'd3,
    SEL_EVN_CDN   = 4'd4,
    SEL_ODD_CUP   = 4'd8,
    SEL_ODD_CDN   = 4'd9
  } trig_sel_e;

  typedef struct packed {
    logic evn_zero;
    logic evn_prd;
    logic evn_cup;
    logic evn_cdn;
    logic odd_cup;
    logic odd_cdn;
  } pair_evt_t;

  // Event qualifying a given code; unlisted codes never qualify.
  function automatic logic code_event(input pair_evt_t e, input int unsigned code);
    logic r;
    case (code)
      int'(SEL_EVN_ZERO): r = e.evn_zero;
      int'(SEL_EVN_PRD):  r = e.evn_prd;
      int'(SEL_EVN_ZP):   r = e.evn_zero | e.evn_prd;
      int'(SEL_EVN_CUP):  r = e.evn_cup;
      int'(SEL_EVN_CDN):  r = e.evn_cdn;
      int'(SEL_ODD_CUP):  r = e.odd_cup;
      int'(SEL_ODD_CDN):  r = e.odd_cdn;
      default:            r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/adctrg_rst_sync.sv
module adctrg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_ready_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_ready_o = sync_q[STAGES-1];
endmodule

// File: rtl/adctrg_decode.sv
module adctrg_decode #(
  parameter int unsigned CODE_W = adctrg_pkg::COND_W
) (
  input  adctrg_pkg::pair_evt_t evt_i,
  input  logic [CODE_W-1:0]     cond_i,
  output logic                  hit_o
);
  localparam int unsigned NCODES = 1 << CODE_W;

  logic [NCODES-1:0] code_hit;

  for (genvar c = 0; c < NCODES; c++) begin : g_code
    assign code_hit[c] = (cond_i == CODE_W'(c)) &&
                         adctrg_pkg::code_event(evt_i, c);
  end

  assign hit_o = |code_hit;
endmodule

// File: rtl/adctrg_flag.sv
module adctrg_flag (
  input  logic clk_i,
  input  logic rst_ready_i,
  input  logic hit_i,
  input  logic en_i,
  input  logic clr_i,
  output logic trig_o,
  output logic flag_o
);
  logic issue;
  logic flag_q;
  logic flag_d;
  logic flag_ce;

  // Trigger leaves in the cycle of the event; gated until reset has settled.
  always_comb begin
    issue   = hit_i & en_i & rst_ready_i;
    flag_ce = issue | clr_i;
    flag_d  = issue;           // set has priority over clear
  end

  always_ff @(posedge clk_i or negedge rst_ready_i) begin
    if (!rst_ready_i)  flag_q <= 1'b0;
    else if (flag_ce)  flag_q <= flag_d;
  end

  assign trig_o = issue;
  assign flag_o = flag_q;
endmodule

// File: rtl/pwm_adc_trig_sel.sv
module pwm_adc_trig_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evn_zero_i,
  input  logic       evn_prd_i,
  input  logic       evn_cmp_up_i,
  input  logic       evn_cmp_dn_i,
  input  logic       odd_cmp_up_i,
  input  logic       odd_cmp_dn_i,
  input  logic [3:0] cond_i,
  input  logic       trig_en_i,
  input  logic       flag_clr_i,
  output logic       trig_o,
  output logic       flag_o
);
  import adctrg_pkg::*;

  pair_evt_t evt;
  logic      rst_ready;
  logic      hit;

  always_comb begin
    evt.evn_zero = evn_zero_i;
    evt.evn_prd  = evn_prd_i;
    evt.evn_cup  = evn_cmp_up_i;
    evt.evn_cdn  = evn_cmp_dn_i;
    evt.odd_cup  = odd_cmp_up_i;
    evt.odd_cdn  = odd_cmp_dn_i;
  end

  adctrg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_ready_o (rst_ready)
  );

  adctrg_decode #(.CODE_W(COND_W)) u_dec (
    .evt_i  (evt),
    .cond_i (cond_i),
    .hit_o  (hit)
  );

  adctrg_flag u_flag (
    .clk_i       (clk_i),
    .rst_ready_i (rst_ready),
    .hit_i       (hit),
    .en_i        (trig_en_i),
    .clr_i       (flag_clr_i),
    .trig_o      (trig_o),
    .flag_o      (flag_o)
  );
endmodule

// File: rtl/adctrg_chk.sv
module adctrg_chk (
  input logic       clk,
  input logic       rdy,
  input logic       zero,
  input logic       prd,
  input logic       ecu,
  input logic       ecd,
  input logic       ocu,
  input logic       ocd,
  input logic [3:0] cond,
  input logic       en,
  input logic       clr,
  input logic       trig,
  input logic       flag
);
  // R1
  zero_sel_chk: assert property (@(posedge clk) disable iff (!rdy)
    (en && cond == 4'd0 && zero) |-> trig);
  // R2
  prd_sel_chk: assert property (@(posedge clk) disable iff (!rdy)
    (en && cond == 4'd1 && prd) |-> trig);
  // R3
  zp_sel_chk: assert property (@(posedge clk) disable iff (!rdy)
    (en && cond == 4'd2 && (zero || prd)) |-> trig);
  // R4
  ecmp_sel_chk: assert property (@(posedge clk) disable iff (!rdy)
    (en && ((cond == 4'd3 && ecu) || (cond == 4'd4 && ecd))) |-> trig);
  // R5
  ocmp_sel_chk: assert property (@(posedge clk) disable iff (!rdy)
    (en && ((cond == 4'd8 && ocu) || (cond == 4'd9 && ocd))) |-> trig);
  // R6
  unlisted_quiet_chk: assert property (@(posedge clk) disable iff (!rdy)
    ((cond >= 4'd5 && cond <= 4'd7) || cond >= 4'd10) |-> !trig);
  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rdy)
    !en |-> !trig);
  // R8
  trig_needs_event_chk: assert property (@(posedge clk) disable iff (!rdy)
    trig |-> (zero || prd || ecu || ecd || ocu || ocd));
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rdy)
    trig |=> flag);
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rdy)
    (flag && !clr) |=> flag);
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rdy)
    (clr && !trig) |=> !flag);
  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rdy |-> (!trig && !flag));
endmodule

bind pwm_adc_trig_sel adctrg_chk chk_i (
  .clk  (clk_i),
  .rdy  (rst_ready),
  .zero (evn_zero_i),
  .prd  (evn_prd_i),
  .ecu  (evn_cmp_up_i),
  .ecd  (evn_cmp_dn_i),
  .ocu  (odd_cmp_up_i),
  .ocd  (odd_cmp_dn_i),
  .cond (cond_i),
  .en   (trig_en_i),
  .clr  (flag_clr_i),
  .trig (trig_o),
  .flag (flag_o)
);

// File: tb/pwm_adc_trig_sel_tb.sv
module pwm_adc_trig_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       zero, prd, ecu, ecd, ocu, ocd;
  logic [3:0] cond;
  logic       en, clr;
  logic       trig, flag;

  int tests = 0;
  int fails = 0;
  bit ref_flag;
  bit ref_trig;

  always #2 clk = ~clk;   // 250 MHz

  pwm_adc_trig_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .evn_zero_i(zero), .evn_prd_i(prd), .evn_cmp_up_i(ecu), .evn_cmp_dn_i(ecd),
    .odd_cmp_up_i(ocu), .odd_cmp_dn_i(ocd),
    .cond_i(cond), .trig_en_i(en), .flag_clr_i(clr),
    .trig_o(trig), .flag_o(flag)
  );

  function automatic bit expect_trig(input int c, input bit e, input bit z, input bit p,
                                     input bit eu, input bit ed, input bit ou, input bit od);
    if (!e) return 0;
    if (c == 0) return z;
    if (c == 1) return p;
    if (c == 2) return z || p;
    if (c == 3) return eu;
    if (c == 4) return ed;
    if (c == 8) return ou;
    if (c == 9) return od;
    return 0;
  endfunction

  function automatic string tag_of(input int c, input bit e);
    if (!e) return "R7";
    if (c == 0) return "R1";
    if (c == 1) return "R2";
    if (c == 2) return "R3";
    if (c == 3 || c == 4) return "R4";
    if (c == 8 || c == 9) return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive on the falling edge, compare, then advance the model.
  task automatic step(input int c, input bit e, input bit z, input bit p, input bit eu,
                      input bit ed, input bit ou, input bit od, input bit cl, input string tg);
    string t;
    @(negedge clk);
    cond = 4'(c); en = e; zero = z; prd = p; ecu = eu; ecd = ed; ocu = ou; ocd = od; clr = cl;
    #1;
    ref_trig = expect_trig(c, e, z, p, eu, ed, ou, od);
    t = (tg != "") ? tg : tag_of(c, e);
    check(t, trig, ref_trig);
    check((cl && ref_trig) ? "R10" : "R9", flag, ref_flag);
    @(posedge clk);
    ref_flag = ref_trig | (ref_flag & ~cl);
  endtask

  task automatic idle(input int n, input string tg);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, tg);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; zero = 0; prd = 0; ecu = 0; ecd = 0; ocu = 0; ocd = 0;
    cond = 4'd0; en = 1'b1; clr = 1'b0; ref_flag = 0;
    repeat (3) @(negedge clk);
    // R11: events offered during reset must not get through
    zero = 1'b1; #1;
    check("R11", trig, 1'b0);
    check("R11", flag, 1'b0);
    zero = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    idle(4, "R11");

    // Sweep every code against each event alone (R1..R6)
    for (int c = 0; c < 16; c++)
      for (int ev = 0; ev < 6; ev++) begin
        step(c, 1, ev == 0, ev == 1, ev == 2, ev == 3, ev == 4, ev == 5, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
      end

    // R3: both zero and period together
    step(2, 1, 1, 1, 0, 0, 0, 0, 0, "R3");

    // R8: one-cycle event gives one-cycle pulse
    step(3, 1, 0, 0, 1, 0, 0, 0, 0, "R8");
    step(3, 1, 0, 0, 0, 0, 0, 0, 0, "R8");

    // R9: flag holds across idle cycles
    idle(5, "R9");
    // R10: clear alone
    step(5, 1, 1, 1, 1, 1, 1, 1, 1, "R10");
    idle(2, "R10");
    // R10: set and clear together with flag clear, then with flag set
    step(9, 1, 0, 0, 0, 0, 0, 1, 1, "R10");
    step(8, 1, 0, 0, 0, 0, 1, 0, 1, "R10");
    idle(2, "R10");
    // R7: enable low with every event active leaves flag clear
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
    for (int c = 0; c < 16; c++) step(c, 0, 1, 1, 1, 1, 1, 1, 0, "R7");
    idle(1, "R7");

    // Pseudo-random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom;
      step(int'(r[3:0]), r[4] | r[5], r[6], r[7], r[8], r[9], r[10], r[11],
           r[12] & r[13], "");
    end

    // R11: reset with flag set clears it at once
    step(0, 1, 1, 0, 0, 0, 0, 0, 0, "R1");
    @(negedge clk); rst_n = 1'b0; #1;
    check("R11", flag, 1'b0);
    ref_flag = 0;
    @(negedge clk); rst_n = 1'b1;
    idle(4, "R11");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule